// File: doc/BRIEF.md
# Pipeline Interlock and Flush Controller

This block produces the stall and cancel controls for a five-stage in-order pipeline made of fetch, operand fetch/decode, execute, memory access and register write-back stages. Each cycle it looks at the instruction in the operand-fetch stage and the instruction in the execute stage, plus the branch outcome computed in execute. From these it decides whether the front of the pipeline must freeze for a cycle, and whether the two youngest instructions must be squashed.

Every data hazard except one is covered by operand forwarding. The exception is a load whose result is needed by the instruction right behind it. The loaded value exists only after memory access, so the controller holds the program counter and the fetch/decode latch for one cycle and turns the decode/execute latch into a bubble. When a branch in execute is taken, the instructions in fetch and in operand fetch are on the wrong path. The controller raises a kill for each of them, and the pipeline clears their valid bits so they never write state. A taken branch wins over a load-use stall seen in the same cycle, because the dependent instruction is being squashed anyway. Structural conflicts cannot arise in this pipeline, so there is no logic for them.

The outputs are combinational in the stage inputs. They are gated by a single flag that is cleared by the synchronous active-low reset and set on the first clock edge after reset is released.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst_n` is low, and from the release of `rst_n` until the next rising clock edge, all five control outputs are 0 whatever the inputs are.
- R2: A load-use stall sets `pc_hold`, `ifof_hold` and `ofex_bubble` to 1 in the same cycle. A load-use stall occurs when `ex_valid`=1, `ex_is_load`=1, `ex_dst_idx`≠0, `of_valid`=1, and some source slot i has `of_src_use[i]`=1 and `of_src_idx[i*REG_AW +: REG_AW]` equal to `ex_dst_idx`.
- R3: A source slot whose `of_src_use` bit is 0 never causes a stall, even if its index field equals the load destination.
- R4: A load whose destination is register 0 (the hardwired zero register) never causes a stall.
- R5: A producer in execute that is not a load (`ex_is_load`=0) never causes a stall, because forwarding covers it.
- R6: No stall is raised when `of_valid`=0 or `ex_valid`=0.
- R7: When `ex_valid`=1 and `ex_br_taken`=1, both `if_kill` and `of_kill` are 1, so exactly two slots are cancelled. Otherwise both are 0.
- R8: When a taken branch and a load-use condition occur in the same cycle, both kills are 1 and all three stall outputs are 0.
- R9: `ex_br_taken` has no effect when `ex_valid`=0.
- R10: A load followed by a dependent instruction yields exactly one bubble over the two-cycle sequence. In the second cycle execute holds the inserted bubble, so no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| of_valid | input | 1 | Operand-fetch stage holds a live instruction |
| of_src_use | input | NUM_SRC | Per source slot: the instruction really reads this register |
| of_src_idx | input | NUM_SRC*REG_AW | Source register indices; slot i at bits [i*REG_AW +: REG_AW] |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_dst_idx | input | REG_AW | Destination register of the execute-stage instruction |
| ex_br_taken | input | 1 | Branch in execute resolved as taken |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifof_hold | output | 1 | Keep the fetch/decode latch unchanged this cycle |
| ofex_bubble | output | 1 | Load a nop into the decode/execute latch this cycle |
| if_kill | output | 1 | Clear the valid bit of the instruction in fetch |
| of_kill | output | 1 | Clear the valid bit of the instruction in operand fetch |

## Verification
The bench targets the match qualifiers. It offers a matching index on a source slot that is not used, a load into register 0, and a matching non-load producer. A design that skipped any of these qualifiers would insert bubbles that forwarding makes unnecessary. It also runs the cycle after a load-use stall, when execute holds the bubble. A design that latched the stall instead of recomputing it would insert two bubbles there. Finally, it presents a taken branch together with a load-use condition, and a taken flag with execute invalid. Wrong priority would freeze a squashed instruction in place, and a missing valid qualifier would flush good instructions.

// File: rtl/pipe_hazard_pkg.sv
// Package: shared types for the pipeline interlock and flush controller.
// Assumes a single-issue five-stage in-order pipeline.
package pipe_hazard_pkg;

    // Control bundle produced by the arbiter each cycle.
    typedef struct packed {
        logic stall;    // freeze PC and fetch/decode latch, bubble into execute
        logic kill_if;  // squash the instruction in fetch
        logic kill_of;  // squash the instruction in operand fetch
    } hzd_ctl_t;

endpackage

// File: rtl/hzd_src_match.sv
// Module: hzd_src_match
// Compares every source slot of the operand-fetch instruction with one
// destination index. Only slots flagged as used may report a hit.
// Assumes slot i occupies bits [i*REG_AW +: REG_AW] of src_idx.
module hzd_src_match #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0]        src_use,
    input  logic [NUM_SRC*REG_AW-1:0] src_idx,
    input  logic [REG_AW-1:0]         dst_idx,
    output logic                      any_hit
);
    logic [NUM_SRC-1:0] slot_hit;

    // One comparator per source slot, qualified by its use bit.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        assign slot_hit[g] = src_use[g] && (src_idx[g*REG_AW +: REG_AW] == dst_idx);
    end

    // Reduce per-slot hits to a single dependence flag.
    assign any_hit = |slot_hit;
endmodule

// File: rtl/hzd_loaduse_detect.sv
// Module: hzd_loaduse_detect
// Flags a load-use hazard: a valid load in execute whose nonzero
// destination is read by the valid instruction in operand fetch.
// Assumes register index ZERO_REG is hardwired and never written.
module hzd_loaduse_detect #(
    parameter int REG_AW   = 5,
    parameter int NUM_SRC  = 2,
    parameter int ZERO_REG = 0
) (
    input  logic                      of_valid,
    input  logic [NUM_SRC-1:0]        of_src_use,
    input  logic [NUM_SRC*REG_AW-1:0] of_src_idx,
    input  logic                      ex_valid,
    input  logic                      ex_is_load,
    input  logic [REG_AW-1:0]         ex_dst_idx,
    output logic                      lu_hazard
);
    localparam logic [REG_AW-1:0] ZERO_IDX = REG_AW'(ZERO_REG);

    logic dep_hit;
    logic producer_late;

    hzd_src_match #(
        .REG_AW (REG_AW),
        .NUM_SRC(NUM_SRC)
    ) i_match (
        .src_use(of_src_use),
        .src_idx(of_src_idx),
        .dst_idx(ex_dst_idx),
        .any_hit(dep_hit)
    );

    // Only a live load to a real register produces its value too late to forward.
    assign producer_late = ex_valid && ex_is_load && (ex_dst_idx != ZERO_IDX);

    // Hazard exists when a live consumer depends on that late producer.
    assign lu_hazard = producer_late && of_valid && dep_hit;
endmodule

// File: rtl/hzd_arbiter.sv
// Module: hzd_arbiter
// Resolves stall and flush requests into one control bundle.
// A taken branch outranks a load-use stall. Nothing is raised until armed.
module hzd_arbiter
    import pipe_hazard_pkg::*;
(
    input  logic     armed,
    input  logic     lu_req,
    input  logic     br_req,
    output hzd_ctl_t ctl
);
    // Priority pick: flush first, else stall, else idle.
    always_comb begin
        ctl = '0;
        if (armed) begin
            if (br_req) begin
                ctl.kill_if = 1'b1;
                ctl.kill_of = 1'b1;
            end else if (lu_req) begin
                ctl.stall = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
// Module: pipe_hazard_ctl (top)
// Interlock and flush controller for a five-stage in-order pipeline.
// Stalls one cycle on load-use only; a taken branch in execute squashes
// the fetch and operand-fetch slots. Outputs are combinational in the stage
// inputs and gated by an arm flag set one edge after reset release.
module pipe_hazard_ctl
    import pipe_hazard_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int NUM_SRC  = 2,
    parameter int ZERO_REG = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      of_valid,
    input  logic [NUM_SRC-1:0]        of_src_use,
    input  logic [NUM_SRC*REG_AW-1:0] of_src_idx,
    input  logic                      ex_valid,
    input  logic                      ex_is_load,
    input  logic [REG_AW-1:0]         ex_dst_idx,
    input  logic                      ex_br_taken,
    output logic                      pc_hold,
    output logic                      ifof_hold,
    output logic                      ofex_bubble,
    output logic                      if_kill,
    output logic                      of_kill
);
    logic     armed_q;
    logic     lu_hazard;
    logic     br_flush;
    hzd_ctl_t ctl;

    // Arm flag: low through reset, set on the first edge after release.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    hzd_loaduse_detect #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC),
        .ZERO_REG(ZERO_REG)
    ) i_lu (
        .of_valid  (of_valid),
        .of_src_use(of_src_use),
        .of_src_idx(of_src_idx),
        .ex_valid  (ex_valid),
        .ex_is_load(ex_is_load),
        .ex_dst_idx(ex_dst_idx),
        .lu_hazard (lu_hazard)
    );

    // A branch only redirects when the execute slot is live.
    assign br_flush = ex_valid && ex_br_taken;

    hzd_arbiter i_arb (
        .armed (armed_q && rst_n),
        .lu_req(lu_hazard),
        .br_req(br_flush),
        .ctl   (ctl)
    );

    // Fan the bundle out to the latch controls.
    assign pc_hold     = ctl.stall;
    assign ifof_hold   = ctl.stall;
    assign ofex_bubble = ctl.stall;
    assign if_kill     = ctl.kill_if;
    assign of_kill     = ctl.kill_of;
endmodule

// File: rtl/pipe_hazard_chk.sv
// Module: pipe_hazard_chk
// Property checker for pipe_hazard_ctl, attached by bind. Observes ports only.
module pipe_hazard_chk #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      of_valid,
    input logic [NUM_SRC-1:0]        of_src_use,
    input logic [NUM_SRC*REG_AW-1:0] of_src_idx,
    input logic                      ex_valid,
    input logic                      ex_is_load,
    input logic [REG_AW-1:0]         ex_dst_idx,
    input logic                      ex_br_taken,
    input logic                      pc_hold,
    input logic                      ifof_hold,
    input logic                      ofex_bubble,
    input logic                      if_kill,
    input logic                      of_kill
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pc_hold && !if_kill && !of_kill) else $error("quiet after reset"); // R1
    AST_HOLDS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold == ifof_hold) && (ifof_hold == ofex_bubble)) else $error("holds disagree"); // R2
    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> ex_valid && ex_is_load && of_valid && (ex_dst_idx != '0) && (|of_src_use)) else $error("stall w/o load"); // R4
    AST_KILLS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        if_kill == of_kill) else $error("kills unpaired"); // R7
    AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        if_kill |-> !pc_hold && !ofex_bubble) else $error("stall during flush"); // R8
    AST_KILL_NEEDS_LIVE_BR: assert property (@(posedge clk) disable iff (!rst_n)
        if_kill |-> ex_valid && ex_br_taken) else $error("kill w/o branch"); // R9
    AST_NO_REPEAT_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ofex_bubble && ex_is_load && !ex_br_taken ##1 !ex_valid |-> !ofex_bubble) else $error("double bubble"); // R10
endmodule

bind pipe_hazard_ctl pipe_hazard_chk #(
    .REG_AW (REG_AW),
    .NUM_SRC(NUM_SRC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .of_valid   (of_valid),
    .of_src_use (of_src_use),
    .of_src_idx (of_src_idx),
    .ex_valid   (ex_valid),
    .ex_is_load (ex_is_load),
    .ex_dst_idx (ex_dst_idx),
    .ex_br_taken(ex_br_taken),
    .pc_hold    (pc_hold),
    .ifof_hold  (ifof_hold),
    .ofex_bubble(ofex_bubble),
    .if_kill    (if_kill),
    .of_kill    (of_kill)
);

// File: tb/test_pipe_hazard_ctl.sv
// Bench for pipe_hazard_ctl: a vector table walked by one loop, then
// directed reset and sequence tests. 50 MHz clock.
module test_pipe_hazard_ctl;
    localparam int REG_AW  = 5;
    localparam int NUM_SRC = 2;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      of_valid = 1'b0;
    logic [NUM_SRC-1:0]        of_src_use = '0;
    logic [NUM_SRC*REG_AW-1:0] of_src_idx = '0;
    logic                      ex_valid = 1'b0;
    logic                      ex_is_load = 1'b0;
    logic [REG_AW-1:0]         ex_dst_idx = '0;
    logic                      ex_br_taken = 1'b0;
    logic                      pc_hold, ifof_hold, ofex_bubble, if_kill, of_kill;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pipe_hazard_ctl #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) i_pipe_hazard_ctl (
        .clk(clk), .rst_n(rst_n),
        .of_valid(of_valid), .of_src_use(of_src_use), .of_src_idx(of_src_idx),
        .ex_valid(ex_valid), .ex_is_load(ex_is_load), .ex_dst_idx(ex_dst_idx),
        .ex_br_taken(ex_br_taken),
        .pc_hold(pc_hold), .ifof_hold(ifof_hold), .ofex_bubble(ofex_bubble),
        .if_kill(if_kill), .of_kill(of_kill)
    );

    typedef struct packed {
        logic [7:0] req;
        logic       ofv;
        logic [1:0] use_b;
        logic [4:0] s1;
        logic [4:0] s0;
        logic       exv;
        logic       ld;
        logic [4:0] dst;
        logic       br;
        logic       x_stall;
        logic       x_kill;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{8'd2, 1'b1, 2'b01, 5'd0,  5'd5, 1'b1, 1'b1, 5'd5,  1'b0, 1'b1, 1'b0}, // R2 slot 0 hit
        '{8'd2, 1'b1, 2'b10, 5'd5,  5'd3, 1'b1, 1'b1, 5'd5,  1'b0, 1'b1, 1'b0}, // R2 slot 1 hit
        '{8'd2, 1'b1, 2'b11, 5'd9,  5'd9, 1'b1, 1'b1, 5'd9,  1'b0, 1'b1, 1'b0}, // R2 both slots
        '{8'd2, 1'b1, 2'b01, 5'd0,  5'd31,1'b1, 1'b1, 5'd31, 1'b0, 1'b1, 1'b0}, // R2 top index
        '{8'd3, 1'b1, 2'b01, 5'd5,  5'd3, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0, 1'b0}, // R3 match on unused slot
        '{8'd3, 1'b1, 2'b00, 5'd5,  5'd5, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0, 1'b0}, // R3 no slot used
        '{8'd4, 1'b1, 2'b11, 5'd0,  5'd0, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0}, // R4 zero register
        '{8'd5, 1'b1, 2'b01, 5'd0,  5'd5, 1'b1, 1'b0, 5'd5,  1'b0, 1'b0, 1'b0}, // R5 ALU producer
        '{8'd6, 1'b0, 2'b01, 5'd0,  5'd5, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0, 1'b0}, // R6 OF invalid
        '{8'd6, 1'b1, 2'b01, 5'd0,  5'd5, 1'b0, 1'b1, 5'd5,  1'b0, 1'b0, 1'b0}, // R6 EX invalid
        '{8'd7, 1'b1, 2'b01, 5'd0,  5'd1, 1'b1, 1'b0, 5'd7,  1'b1, 1'b0, 1'b1}, // R7 taken branch
        '{8'd8, 1'b1, 2'b01, 5'd0,  5'd5, 1'b1, 1'b1, 5'd5,  1'b1, 1'b0, 1'b1}, // R8 branch beats stall
        '{8'd9, 1'b1, 2'b01, 5'd0,  5'd5, 1'b0, 1'b0, 5'd5,  1'b1, 1'b0, 1'b0}  // R9 dead branch
    };

    task automatic check(input int req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic xs, input logic xk);
        check(req, "pc_hold",     pc_hold,     xs);
        check(req, "ifof_hold",   ifof_hold,   xs);
        check(req, "ofex_bubble", ofex_bubble, xs);
        check(req, "if_kill",     if_kill,     xk);
        check(req, "of_kill",     of_kill,     xk);
    endtask

    task automatic drive(input vec_t v);
        of_valid    = v.ofv;
        of_src_use  = v.use_b;
        of_src_idx  = {v.s1, v.s0};
        ex_valid    = v.exv;
        ex_is_load  = v.ld;
        ex_dst_idx  = v.dst;
        ex_br_taken = v.br;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int bubbles;
        int kills;
        // R1: hazard and branch presented during reset.
        @(negedge clk);
        drive(VEC[11]);
        ex_br_taken = 1'b0;
        #2 check_all(1, 1'b0, 1'b0);
        ex_br_taken = 1'b1;
        #2 check_all(1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1: release, then quiet until the next rising edge.
        ex_br_taken = 1'b0;
        rst_n = 1'b1;
        #2 check_all(1, 1'b0, 1'b0);
        @(negedge clk);
        #2 check(2, "pc_hold armed", pc_hold, 1'b1);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #2 check_all(int'(VEC[i].req), VEC[i].x_stall, VEC[i].x_kill);
        end

        // R10: load then dependent add; second cycle EX holds the bubble.
        bubbles = 0;
        @(negedge clk);
        drive(VEC[0]);
        #2 bubbles += int'(ofex_bubble);
        @(negedge clk);
        ex_valid = 1'b0; ex_is_load = 1'b0;
        #2 bubbles += int'(ofex_bubble);
        check(10, "one bubble after load-use", bubbles == 1, 1'b1);

        // R5: add followed by dependent add, two cycles, no bubble.
        bubbles = 0;
        @(negedge clk);
        drive(VEC[7]);
        #2 bubbles += int'(ofex_bubble);
        @(negedge clk);
        ex_dst_idx = 5'd3; of_src_idx = {5'd0, 5'd3};
        #2 bubbles += int'(ofex_bubble);
        check(5, "zero bubbles add-add", bubbles == 0, 1'b1);

        // R7: taken branch kills exactly two slots; next cycle EX is a dead slot.
        kills = 0;
        @(negedge clk);
        drive(VEC[10]);
        #2 kills += int'(if_kill) + int'(of_kill);
        @(negedge clk);
        ex_valid = 1'b0;
        #2 kills += int'(if_kill) + int'(of_kill);
        check(7, "two killed slots", kills == 2, 1'b1);

        // R1: reassert reset mid-run with a hazard present.
        @(negedge clk);
        drive(VEC[0]);
        rst_n = 1'b0;
        #2 check_all(1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #2 check_all(1, 1'b0, 1'b0);
        @(negedge clk);
        #2 check_all(2, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule